// File: doc/BRIEF.md
# Asynchronous SRAM Access Sequencer

This block sits between a clocked host and a 32K x 8 asynchronous static RAM. The host offers one word at a time over a valid/ready handshake, with a write flag, a 15-bit address and a data byte. The sequencer turns each request into a timed pattern on the memory's active-low chip select, write strobe and output strobe, its address pins and a shared data bus. The bus is split into out, in and drive-enable signals for the pad ring to combine.

Every phase length is a whole number of clock cycles: the ceiling of a nanosecond limit divided by the clock period, never less than one. The limits and the period are parameters. With the defaults (8 ns clock, 55 ns speed grade) a read holds the strobes for 7 cycles and a write pulse lasts 7 cycles. Between accesses the memory rests with chip select high, so the address only moves while the memory ignores it. After reset the memory is assumed to come out of low-voltage retention, so the first access waits one full read-cycle time with chip select low before any strobe falls.

Read data is taken from the bus on the last cycle of the read window and shown to the host with a one-cycle valid pulse.

Top module: `sram_ctrl`

## Requirements
- R1: While reset is held and right after it, chip select, write strobe and output strobe are high, the data drivers are off, ready is high and read-valid is low.
- R2: A read holds chip select and output strobe low with the write strobe high for N_RD = max(ceil(55/P), ceil(30/P)) cycles, where P is the clock period in ns (7 at P = 8). The bus value in the last of those cycles is returned on rd_data_o with rd_valid_o high for exactly one cycle.
- R3: A write holds chip select and write strobe low with the output strobe high for N_WP = max(ceil(45/P), ceil(50/P), ceil(25/P)+1) cycles (7 at P = 8). The memory stores the byte present on the bus when the strobe rises.
- R4: The memory address changes only in a cycle where chip select and write strobe are both high.
- R5: The data drivers are off in the first cycle of the write pulse. They are on from the second cycle until one cycle after the write strobe rises, and are never on while the output strobe is low.
- R6: After each access, chip select and both strobes stay high for at least N_GAP = ceil(20/P) cycles (3 at P = 8) before ready returns.
- R7: The first access after reset holds chip select low with both strobes high for N_RC = ceil(55/P) cycles (7) before its strobe falls. Later accesses lower their strobe in the same cycle as chip select.
- R8: Ready is high only while no access is in progress. It is low whenever chip select is low.
- R9: Output strobe and write strobe are never low together, and neither is low while chip select is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_valid_i | input | 1 | Host request valid |
| req_ready_o | output | 1 | Sequencer idle, request accepted on valid and ready |
| req_we_i | input | 1 | 1 for write, 0 for read |
| req_addr_i | input | 15 | Word address |
| req_wdata_i | input | 8 | Write byte |
| rd_data_o | output | 8 | Read byte |
| rd_valid_o | output | 1 | One-cycle pulse when rd_data_o is new |
| sram_ce_no | output | 1 | Memory chip select, active low |
| sram_we_no | output | 1 | Memory write strobe, active low |
| sram_oe_no | output | 1 | Memory output strobe, active low |
| sram_addr_o | output | 15 | Memory address |
| sram_dq_o | output | 8 | Data toward the memory |
| sram_dq_i | input | 8 | Data from the memory |
| sram_dq_oe_o | output | 1 | Drive enable for sram_dq_o |

## Verification
The bench models a memory that returns garbage until the access and output-strobe times have passed. A read window that is one cycle short therefore returns a wrong byte. It watches the bus for a driver that turns on in the first write cycle or drops before the strobe rises; either would corrupt or race the stored byte. It counts the cycles between chip select falling and the first strobe, so a design that skips the recovery wait, or repeats it on every access, is caught. Address moves while the memory is selected and a gap after an access that is too short are reported as well.

// File: rtl/sram_ctrl_pkg.sv
package sram_ctrl_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_ADDR,
    ST_WAKE,
    ST_RD,
    ST_WR,
    ST_WREL,
    ST_GAP
  } phase_e;

  function automatic int unsigned ns2cyc(input int unsigned ns, input int unsigned per);
    int unsigned c;
    c = (ns + per - 1) / per;
    return (c == 0) ? 1 : c;
  endfunction

  function automatic int unsigned max3(input int unsigned a, input int unsigned b,
                                       input int unsigned c);
    int unsigned m;
    m = (a > b) ? a : b;
    return (m > c) ? m : c;
  endfunction

endpackage

// File: rtl/sram_phase_timer.sv
module sram_phase_timer #(
  parameter int unsigned CNT_W = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             load_i,
  input  logic [CNT_W-1:0] load_val_i,
  output logic             done_o
);

  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
    end else if (load_i) begin
      cnt_q <= load_val_i - CNT_W'(1);
    end else if (cnt_q != '0) begin
      cnt_q <= cnt_q - CNT_W'(1);
    end
  end

  assign done_o = (cnt_q == '0);

endmodule

// File: rtl/sram_ctrl_fsm.sv
module sram_ctrl_fsm
  import sram_ctrl_pkg::*;
#(
  parameter int unsigned N_RD  = 7,
  parameter int unsigned N_WP  = 7,
  parameter int unsigned N_RC  = 7,
  parameter int unsigned N_GAP = 3,
  parameter int unsigned CNT_W = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             req_valid_i,
  input  logic             req_we_i,
  input  logic             done_i,
  output logic             ready_o,
  output logic             accept_o,
  output logic             capture_o,
  output logic             load_o,
  output logic [CNT_W-1:0] load_val_o,
  output phase_e           state_q_o,
  output phase_e           state_d_o
);

  phase_e state_q, state_d;
  logic   wr_q;
  logic   cold_q;

  assign ready_o  = (state_q == ST_IDLE);
  assign accept_o = ready_o && req_valid_i;

  always_comb begin
    state_d    = state_q;
    load_o     = 1'b0;
    load_val_o = '0;
    capture_o  = 1'b0;
    unique case (state_q)
      ST_IDLE: if (req_valid_i) state_d = ST_ADDR;
      ST_ADDR: begin
        load_o = 1'b1;
        if (cold_q) begin
          state_d    = ST_WAKE;
          load_val_o = CNT_W'(N_RC);
        end else if (wr_q) begin
          state_d    = ST_WR;
          load_val_o = CNT_W'(N_WP);
        end else begin
          state_d    = ST_RD;
          load_val_o = CNT_W'(N_RD);
        end
      end
      ST_WAKE: if (done_i) begin
        load_o = 1'b1;
        if (wr_q) begin
          state_d    = ST_WR;
          load_val_o = CNT_W'(N_WP);
        end else begin
          state_d    = ST_RD;
          load_val_o = CNT_W'(N_RD);
        end
      end
      ST_RD: if (done_i) begin
        capture_o  = 1'b1;
        state_d    = ST_GAP;
        load_o     = 1'b1;
        load_val_o = CNT_W'(N_GAP);
      end
      ST_WR: if (done_i) state_d = ST_WREL;
      ST_WREL: begin
        state_d    = ST_GAP;
        load_o     = 1'b1;
        load_val_o = CNT_W'(N_GAP);
      end
      ST_GAP: if (done_i) state_d = ST_IDLE;
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      wr_q    <= 1'b0;
      cold_q  <= 1'b1;
    end else begin
      state_q <= state_d;
      if (accept_o) wr_q <= req_we_i;
      if (state_q == ST_WAKE && done_i) cold_q <= 1'b0;
    end
  end

  assign state_q_o = state_q;
  assign state_d_o = state_d;

endmodule

// File: rtl/sram_ctrl_pins.sv
module sram_ctrl_pins
  import sram_ctrl_pkg::*;
#(
  parameter int unsigned ADDR_W = 15,
  parameter int unsigned DATA_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  phase_e            state_q_i,
  input  phase_e            state_d_i,
  input  logic              accept_i,
  input  logic              capture_i,
  input  logic [ADDR_W-1:0] req_addr_i,
  input  logic [DATA_W-1:0] req_wdata_i,
  input  logic [DATA_W-1:0] sram_dq_i,
  output logic              sram_ce_no,
  output logic              sram_we_no,
  output logic              sram_oe_no,
  output logic [ADDR_W-1:0] sram_addr_o,
  output logic [DATA_W-1:0] sram_dq_o,
  output logic              sram_dq_oe_o,
  output logic [DATA_W-1:0] rd_data_o,
  output logic              rd_valid_o
);

  logic selected_d;
  assign selected_d = (state_d_i == ST_WAKE) || (state_d_i == ST_RD) || (state_d_i == ST_WR);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sram_ce_no   <= 1'b1;
      sram_we_no   <= 1'b1;
      sram_oe_no   <= 1'b1;
      sram_dq_oe_o <= 1'b0;
      sram_addr_o  <= '0;
      sram_dq_o    <= '0;
      rd_data_o    <= '0;
      rd_valid_o   <= 1'b0;
    end else begin
      sram_ce_no   <= !selected_d;
      sram_we_no   <= (state_d_i != ST_WR);
      sram_oe_no   <= (state_d_i != ST_RD);
      // on from the 2nd pulse cycle, held through the release cycle
      sram_dq_oe_o <= (state_q_i == ST_WR);
      rd_valid_o   <= capture_i;
      if (accept_i) begin
        sram_addr_o <= req_addr_i;
        sram_dq_o   <= req_wdata_i;
      end
      if (capture_i) rd_data_o <= sram_dq_i;
    end
  end

endmodule

// File: rtl/sram_ctrl.sv
module sram_ctrl
  import sram_ctrl_pkg::*;
#(
  parameter int unsigned CLK_PERIOD_NS = 8,
  parameter int unsigned ADDR_W        = 15,
  parameter int unsigned DATA_W        = 8,
  parameter int unsigned T_RC_NS       = 55,
  parameter int unsigned T_AA_NS       = 55,
  parameter int unsigned T_OE_NS       = 30,
  parameter int unsigned T_OHZ_NS      = 20,
  parameter int unsigned T_WP_NS       = 45,
  parameter int unsigned T_AW_NS       = 50,
  parameter int unsigned T_DW_NS       = 25
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_valid_i,
  output logic              req_ready_o,
  input  logic              req_we_i,
  input  logic [ADDR_W-1:0] req_addr_i,
  input  logic [DATA_W-1:0] req_wdata_i,
  output logic [DATA_W-1:0] rd_data_o,
  output logic              rd_valid_o,
  output logic              sram_ce_no,
  output logic              sram_we_no,
  output logic              sram_oe_no,
  output logic [ADDR_W-1:0] sram_addr_o,
  output logic [DATA_W-1:0] sram_dq_o,
  input  logic [DATA_W-1:0] sram_dq_i,
  output logic              sram_dq_oe_o
);

  localparam int unsigned N_RD  = max3(ns2cyc(T_AA_NS, CLK_PERIOD_NS),
                                       ns2cyc(T_OE_NS, CLK_PERIOD_NS),
                                       ns2cyc(T_RC_NS, CLK_PERIOD_NS));
  // drivers start one cycle into the pulse, so setup needs one extra
  localparam int unsigned N_WP  = max3(ns2cyc(T_WP_NS, CLK_PERIOD_NS),
                                       ns2cyc(T_AW_NS, CLK_PERIOD_NS),
                                       ns2cyc(T_DW_NS, CLK_PERIOD_NS) + 1);
  localparam int unsigned N_RC  = ns2cyc(T_RC_NS, CLK_PERIOD_NS);
  localparam int unsigned N_GAP = ns2cyc(T_OHZ_NS, CLK_PERIOD_NS);
  localparam int unsigned N_MAX = max3(max3(N_RD, N_WP, N_RC), N_GAP, 1);
  localparam int unsigned CNT_W = $clog2(N_MAX + 1);

  phase_e           state_q, state_d;
  logic             accept, capture, load, done;
  logic [CNT_W-1:0] load_val;

  sram_ctrl_fsm #(
    .N_RD (N_RD),
    .N_WP (N_WP),
    .N_RC (N_RC),
    .N_GAP(N_GAP),
    .CNT_W(CNT_W)
  ) u_fsm (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .req_valid_i(req_valid_i),
    .req_we_i   (req_we_i),
    .done_i     (done),
    .ready_o    (req_ready_o),
    .accept_o   (accept),
    .capture_o  (capture),
    .load_o     (load),
    .load_val_o (load_val),
    .state_q_o  (state_q),
    .state_d_o  (state_d)
  );

  sram_phase_timer #(
    .CNT_W(CNT_W)
  ) u_timer (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .load_i    (load),
    .load_val_i(load_val),
    .done_o    (done)
  );

  sram_ctrl_pins #(
    .ADDR_W(ADDR_W),
    .DATA_W(DATA_W)
  ) u_pins (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .state_q_i   (state_q),
    .state_d_i   (state_d),
    .accept_i    (accept),
    .capture_i   (capture),
    .req_addr_i  (req_addr_i),
    .req_wdata_i (req_wdata_i),
    .sram_dq_i   (sram_dq_i),
    .sram_ce_no  (sram_ce_no),
    .sram_we_no  (sram_we_no),
    .sram_oe_no  (sram_oe_no),
    .sram_addr_o (sram_addr_o),
    .sram_dq_o   (sram_dq_o),
    .sram_dq_oe_o(sram_dq_oe_o),
    .rd_data_o   (rd_data_o),
    .rd_valid_o  (rd_valid_o)
  );

endmodule

// File: rtl/sram_ctrl_chk.sv
module sram_ctrl_chk #(
  parameter int unsigned ADDR_W = 15
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              ready,
  input logic              rvalid,
  input logic              ce_n,
  input logic              we_n,
  input logic              oe_n,
  input logic [ADDR_W-1:0] addr,
  input logic              dq_oe
);

  assert_rvalid_pulse_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rvalid |=> !rvalid);

  assert_addr_quiet_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(addr) |-> (ce_n && we_n));

  assert_drv_late_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(we_n) |-> !dq_oe);

  assert_drv_hold_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(we_n) |-> dq_oe);

  assert_no_contention_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dq_oe |-> oe_n);

  assert_busy_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !ce_n |-> !ready);

  assert_strobe_excl_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(oe_n || we_n) |-> 1'b0);

  assert_strobe_sel_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ce_n |-> (oe_n && we_n));

endmodule

bind sram_ctrl sram_ctrl_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk_i (clk_i),
  .rst_ni(rst_ni),
  .ready (req_ready_o),
  .rvalid(rd_valid_o),
  .ce_n  (sram_ce_no),
  .we_n  (sram_we_no),
  .oe_n  (sram_oe_no),
  .addr  (sram_addr_o),
  .dq_oe (sram_dq_oe_o)
);

// File: tb/sram_ctrl_test.sv
module sram_ctrl_test;

  localparam int P = 8;

  function automatic int cyc(input int ns);
    int c;
    c = (ns + P - 1) / P;
    return (c < 1) ? 1 : c;
  endfunction
  function automatic int mx(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

  localparam int E_RD   = mx(cyc(55), cyc(30));
  localparam int E_WP   = mx(mx(cyc(45), cyc(50)), cyc(25) + 1);
  localparam int E_GAP  = cyc(20);
  localparam int E_RC   = cyc(55);
  localparam int E_MEMA = mx(cyc(55), cyc(30));

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        req_valid_i = 1'b0;
  logic        req_ready_o;
  logic        req_we_i = 1'b0;
  logic [14:0] req_addr_i = '0;
  logic [7:0]  req_wdata_i = '0;
  logic [7:0]  rd_data_o;
  logic        rd_valid_o;
  logic        sram_ce_no, sram_we_no, sram_oe_no, sram_dq_oe_o;
  logic [14:0] sram_addr_o;
  logic [7:0]  sram_dq_o;
  logic [7:0]  sram_dq_i = 8'hEE;

  int checks = 0;
  int fails  = 0;
  bit finished = 0;

  logic [7:0] mem_arr [int];
  logic [7:0] shadow  [int];
  logic [7:0] exp_q [$];

  always #4 clk_i = ~clk_i;

  sram_ctrl uut (
    .clk_i(clk_i), .rst_ni(rst_ni),
    .req_valid_i(req_valid_i), .req_ready_o(req_ready_o), .req_we_i(req_we_i),
    .req_addr_i(req_addr_i), .req_wdata_i(req_wdata_i),
    .rd_data_o(rd_data_o), .rd_valid_o(rd_valid_o),
    .sram_ce_no(sram_ce_no), .sram_we_no(sram_we_no), .sram_oe_no(sram_oe_no),
    .sram_addr_o(sram_addr_o), .sram_dq_o(sram_dq_o), .sram_dq_i(sram_dq_i),
    .sram_dq_oe_o(sram_dq_oe_o)
  );

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s act=%0h exp=%0h t=%0t", tag, act, exp, $time);
    end
  endtask

  task automatic do_req(input logic we, input logic [14:0] a, input logic [7:0] d);
    @(negedge clk_i);
    while (!req_ready_o) @(negedge clk_i);
    req_valid_i = 1'b1;
    req_we_i    = we;
    req_addr_i  = a;
    req_wdata_i = d;
    if (we) shadow[int'(a)] = d;
    else exp_q.push_back(shadow.exists(int'(a)) ? shadow[int'(a)] : 8'h00);
    @(negedge clk_i);
    req_valid_i = 1'b0;
  endtask

  // memory model and pin-order monitor
  int rd_cnt = 0, wp_cnt = 0, oe_cnt = 0, pre_cnt = 0, hi_cnt = 0;
  bit first_acc = 1, prev_wr = 0, prev_oe_lo = 0, prev_strobe = 0, prev_rv = 0;
  bit prev_ready = 1;
  logic [14:0] prev_addr = '0;

  always @(negedge clk_i) begin
    if (rst_ni) begin
      bit wr_act, strobe;
      wr_act = !sram_ce_no && !sram_we_no;
      strobe = !sram_we_no || !sram_oe_no;

      if (!sram_ce_no && !sram_oe_no && sram_we_no) rd_cnt++; else rd_cnt = 0;
      sram_dq_i = (rd_cnt >= E_MEMA) ?
                  (mem_arr.exists(int'(sram_addr_o)) ? mem_arr[int'(sram_addr_o)] : 8'h00) : 8'hEE;

      if (sram_addr_o != prev_addr)
        check(sram_ce_no && sram_we_no, "R4 addr moved while selected",
              {sram_ce_no, sram_we_no}, 2'b11);

      if (wr_act) begin
        wp_cnt++;
        if (wp_cnt == 1) check(!sram_dq_oe_o, "R5 driver on in first pulse cycle", sram_dq_oe_o, 0);
      end
      if (prev_wr && !wr_act) begin
        check(wp_cnt == E_WP, "R3 write pulse length", wp_cnt, E_WP);
        check(sram_dq_oe_o, "R5 driver dropped before strobe end", sram_dq_oe_o, 1);
        check(!sram_oe_no == 1'b0, "R3 output strobe low in write", sram_oe_no, 1);
        mem_arr[int'(sram_addr_o)] = sram_dq_o;
        wp_cnt = 0;
      end
      prev_wr = wr_act;
      if (sram_dq_oe_o && !sram_oe_no) check(0, "R5 bus contention", 1, 0);

      if (!sram_oe_no) oe_cnt++;
      if (prev_oe_lo && sram_oe_no) begin
        check(oe_cnt == E_RD, "R2 read window length", oe_cnt, E_RD);
        oe_cnt = 0;
      end
      prev_oe_lo = !sram_oe_no;

      if (!sram_ce_no && !strobe) pre_cnt++;
      if (strobe && !prev_strobe) begin
        check(pre_cnt == (first_acc ? E_RC : 0), "R7 select-to-strobe delay",
              pre_cnt, first_acc ? E_RC : 0);
        first_acc = 0;
      end
      if (sram_ce_no) pre_cnt = 0;
      prev_strobe = strobe;

      if (!sram_we_no && !sram_oe_no) check(0, "R9 both strobes low", 0, 1);
      if (sram_ce_no && strobe) check(0, "R9 strobe without select", 0, 1);
      if (!sram_ce_no && req_ready_o) check(0, "R8 ready while selected", 1, 0);

      if (!sram_ce_no || sram_dq_oe_o) hi_cnt = 0; else hi_cnt++;
      if (req_ready_o && !prev_ready)
        check(hi_cnt >= E_GAP + 1, "R6 gap after access", hi_cnt, E_GAP + 1);
      prev_ready = req_ready_o;

      if (rd_valid_o) begin
        if (prev_rv) check(0, "R2 valid longer than one cycle", 1, 0);
        if (exp_q.size() == 0) check(0, "R2 unexpected read data", rd_data_o, 0);
        else begin
          logic [7:0] e;
          e = exp_q.pop_front();
          check(rd_data_o == e, "R2 read data", rd_data_o, e);
        end
      end
      prev_rv = rd_valid_o;
      prev_addr = sram_addr_o;
    end
  end

  task automatic finish_run();
    if (!finished) begin
      finished = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk_i);
    check(0, "watchdog expired", 0, 1);
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk_i);
    check(sram_ce_no && sram_we_no && sram_oe_no && !sram_dq_oe_o && req_ready_o && !rd_valid_o,
          "R1 reset state", {sram_ce_no, sram_we_no, sram_oe_no, sram_dq_oe_o, req_ready_o, rd_valid_o},
          6'b111010);
    rst_ni = 1'b1;
    @(negedge clk_i);
    check(sram_ce_no && sram_we_no && sram_oe_no && !sram_dq_oe_o && req_ready_o,
          "R1 after reset", {sram_ce_no, sram_we_no, sram_oe_no, sram_dq_oe_o, req_ready_o}, 5'b11101);

    do_req(1'b1, 15'h0000, 8'h11);
    do_req(1'b1, 15'h7FFF, 8'hA5);
    do_req(1'b1, 15'h1234, 8'h5A);
    do_req(1'b1, 15'h0001, 8'hFF);
    do_req(1'b0, 15'h0000, 8'h00);
    do_req(1'b0, 15'h7FFF, 8'h00);
    do_req(1'b0, 15'h1234, 8'h00);
    do_req(1'b0, 15'h0001, 8'h00);
    do_req(1'b0, 15'h4000, 8'h00);
    do_req(1'b1, 15'h1234, 8'h00);
    do_req(1'b0, 15'h1234, 8'h00);
    for (int i = 0; i < 8; i++) do_req(1'b1, 15'(i * 32'h1111), 8'(i * 37 + 3));
    for (int i = 7; i >= 0; i--) do_req(1'b0, 15'(i * 32'h1111), 8'h00);
    for (int i = 0; i < 4; i++) begin
      do_req(1'b1, 15'(16'h0100 + i), 8'(8'hC0 ^ i));
      do_req(1'b0, 15'(16'h0100 + i), 8'h00);
    end

    while (exp_q.size() != 0 || !req_ready_o) @(negedge clk_i);
    repeat (4) @(negedge clk_i);
    check(exp_q.size() == 0, "R2 all reads returned", exp_q.size(), 0);
    finish_run();
  end

endmodule